// File: doc/BRIEF.md
# ADC Threshold Compare Scanner

This block sits behind an analog converter that runs an automatic scan over a set of inputs. Each conversion result arrives with a valid strobe, and the final result of a pass also carries an end marker. The block counts arrivals to give each result its channel number. It tests the result against that channel's threshold using one of four match rules, and stores or drops the result according to the selected storage mode. It raises a one-cycle interrupt according to the selected interrupt mode. When a pass ends it can also pulse a request asking the system to drop back to low-power operation.

Software uses a small word-wide register port. Address 0 holds the control byte. The next `NCH` addresses hold the threshold file. The `NCH` addresses after those read back the result store. The two threshold entries of an even/odd pair also act as the low and high bounds of a window, which both windowed rules use.

Top module: `adc_thresh_scan`

## Requirements
- R1: After reset every control field is zero, every threshold is zero and all outputs are low. The control word at address 0 keeps only bits 7:0: scan enable in bit 0, low-power request enable in bit 1, interrupt mode in bits 3:2, store mode in bits 5:4 and match rule in bits 7:6. Bits 15:8 always read as zero.
- R2: A write to address `NCH+i` sets threshold i. Reading that address returns the threshold. Reading address `2*NCH+i` returns result slot i. Read data appears one clock after the address is presented.
- R3: Accepted results are tagged 0, 1, 2, … in order. The result after one carrying the end marker is tagged 0 again, and the tag wraps from `NCH-1` to 0.
- R4: Match rule 0 hits when result < threshold[tag]. Rule 1 hits when result > threshold[tag].
- R5: With lo = threshold[tag with bit 0 cleared] and hi = threshold[tag with bit 0 set], rule 2 hits when lo <= result <= hi. Rule 3 hits when result < lo or result > hi.
- R6: Store mode 1 writes each result to slot [tag]. Store mode 0 writes results to consecutive slots from a pointer. The pointer wraps at `NCH`, is not cleared by the end marker, and is cleared by any write to the control word.
- R7: Store mode 2 writes nothing but still reports hits. Store mode 3 writes nothing and reports no hit.
- R8: Interrupt mode 0 never fires. Mode 1 fires on each result carrying the end marker. Mode 2 fires on each hit.
- R9: Interrupt mode 3 fires on an end-marked result only if a hit occurred among the results of that pass. The collected hit state is cleared once a pass ends.
- R10: `lowpwr_req` pulses on an end-marked result exactly when low-power request enable is set.
- R11: A result presented while scan enable is clear produces no output. It is not stored and does not advance the tag or the pointer.
- R12: `hit`, `hit_chan`, `irq` and `lowpwr_req` are registered. They show the outcome of a result one clock after it is accepted, and the pulses last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | CW+2 | Register word address |
| reg_wdata | input | BW | Register write data |
| reg_rdata | output | BW | Register read data, one cycle after address |
| res_valid | input | 1 | Conversion result valid |
| res_data | input | DW | Unsigned conversion result |
| res_last | input | 1 | Marks the final result of a scan pass |
| hit | output | 1 | Match pulse for the previous accepted result |
| hit_chan | output | CW | Tag of the last accepted result |
| irq | output | 1 | Interrupt pulse |
| lowpwr_req | output | 1 | Return-to-low-power request pulse |

## Verification
Every scan output is due one clock after the edge that accepts the result. The driver therefore queues its prediction just after that edge, and the monitor compares it on the following falling edge, before any later result can disturb the outputs. Register reads are compared on the falling edge after the single registering edge. Idle checks take one extra cycle after the last queued item to confirm that the pulses have returned low.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic [1:0] {CMP_LT = 2'd0, CMP_GT = 2'd1, CMP_IN = 2'd2, CMP_OUT = 2'd3} cmp_mode_e;
  typedef enum logic [1:0] {WR_PTR = 2'd0, WR_CHAN = 2'd1, WR_NONE = 2'd2, WR_RSVD = 2'd3} wr_mode_e;
  typedef enum logic [1:0] {IRQ_OFF = 2'd0, IRQ_SEQ = 2'd1, IRQ_HIT = 2'd2, IRQ_SEQ_HIT = 2'd3} irq_mode_e;

  // packed from bit 7 down to bit 0
  typedef struct packed {
    cmp_mode_e cmp;
    wr_mode_e  wr;
    irq_mode_e irq;
    logic      lp_en;
    logic      scan_en;
  } ctrl_t;
endpackage

// File: rtl/adc_scan_regs.sv
module adc_scan_regs
  import adc_scan_pkg::*;
#(
  parameter int NCH = 16,
  parameter int DW  = 12,
  parameter int BW  = 16,
  localparam int CW = $clog2(NCH),
  localparam int AW = CW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] wdata,
  output ctrl_t         ctrl,
  output logic          ctrl_wr,
  output logic [DW-1:0] thr [NCH],
  output logic [BW-1:0] rd_q,
  output logic          rd_res_q
);
  localparam logic [1:0] RG_CTRL = 2'd0;
  localparam logic [1:0] RG_THR  = 2'd1;
  localparam logic [1:0] RG_RES  = 2'd2;

  logic [1:0]    region;
  logic [CW-1:0] loc;
  logic [BW-1:0] unused_wdata;

  assign region       = addr[AW-1:CW];
  assign loc          = addr[CW-1:0];
  assign ctrl_wr      = we && region == RG_CTRL && loc == '0;
  assign unused_wdata = wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      for (int i = 0; i < NCH; i++) thr[i] <= '0;
    end else if (we) begin
      if (ctrl_wr) ctrl <= ctrl_t'(wdata[7:0]);
      if (region == RG_THR) thr[loc] <= wdata[DW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q     <= '0;
      rd_res_q <= 1'b0;
    end else begin
      rd_res_q <= region == RG_RES;
      if (region == RG_CTRL && loc == '0) rd_q <= {{(BW-8){1'b0}}, ctrl};
      else if (region == RG_THR)          rd_q <= {{(BW-DW){1'b0}}, thr[loc]};
      else                                rd_q <= '0;
    end
  end
endmodule

// File: rtl/adc_scan_cmp.sv
module adc_scan_cmp
  import adc_scan_pkg::*;
#(
  parameter int NCH = 16,
  parameter int DW  = 12,
  localparam int CW = $clog2(NCH)
) (
  input  cmp_mode_e     mode,
  input  logic [DW-1:0] res,
  input  logic [CW-1:0] chan,
  input  logic [DW-1:0] thr [NCH],
  output logic          hit_raw
);
  logic [CW-1:0] lo_i, hi_i;
  logic [DW-1:0] own, lo, hi;

  assign lo_i = chan & ~CW'(1);
  assign hi_i = chan | CW'(1);
  assign own  = thr[chan];
  assign lo   = thr[lo_i];
  assign hi   = thr[hi_i];

  always_comb begin
    unique case (mode)
      CMP_LT:  hit_raw = res < own;
      CMP_GT:  hit_raw = res > own;
      CMP_IN:  hit_raw = (res >= lo) && (res <= hi);
      default: hit_raw = (res < lo) || (res > hi);
    endcase
  end
endmodule

// File: rtl/adc_scan_store.sv
module adc_scan_store
  import adc_scan_pkg::*;
#(
  parameter int NCH = 16,
  parameter int DW  = 12,
  localparam int CW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc,
  input  wr_mode_e      mode,
  input  logic [DW-1:0] res,
  input  logic [CW-1:0] chan,
  input  logic          ptr_clr,
  input  logic [CW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          mem_we
);
  logic [DW-1:0] mem [NCH];
  logic [CW-1:0] ptr;
  logic [CW-1:0] waddr;

  assign mem_we = acc && (mode == WR_PTR || mode == WR_CHAN);
  assign waddr  = (mode == WR_PTR) ? ptr : chan;

  always_ff @(posedge clk) begin
    if (rst || ptr_clr)              ptr <= '0;
    else if (acc && mode == WR_PTR)  ptr <= ptr + 1'b1;
  end

  // simple dual-port RAM: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (mem_we) mem[waddr] <= res;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NCH = 16,
  localparam int CW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc,
  input  logic          last,
  input  logic          hit_raw,
  input  wr_mode_e      wmode,
  input  irq_mode_e     imode,
  input  logic          lp_en,
  output logic [CW-1:0] chan,
  output logic          hit,
  output logic [CW-1:0] hit_chan,
  output logic          irq,
  output logic          lowpwr_req
);
  logic sticky;
  logic hit_ok;
  logic seen;
  logic fire;

  assign hit_ok = hit_raw && wmode != WR_RSVD;
  assign seen   = sticky || hit_ok;

  always_comb begin
    unique case (imode)
      IRQ_OFF:     fire = 1'b0;
      IRQ_SEQ:     fire = last;
      IRQ_HIT:     fire = hit_ok;
      default:     fire = last && seen;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chan       <= '0;
      sticky     <= 1'b0;
      hit        <= 1'b0;
      hit_chan   <= '0;
      irq        <= 1'b0;
      lowpwr_req <= 1'b0;
    end else begin
      hit        <= 1'b0;
      irq        <= 1'b0;
      lowpwr_req <= 1'b0;
      if (acc) begin
        hit        <= hit_ok;
        hit_chan   <= chan;
        irq        <= fire;
        lowpwr_req <= last && lp_en;
        chan       <= last ? '0 : chan + 1'b1;
        sticky     <= last ? 1'b0 : seen;
      end
    end
  end
endmodule

// File: rtl/adc_thresh_scan.sv
module adc_thresh_scan
  import adc_scan_pkg::*;
#(
  parameter int NCH = 16,
  parameter int DW  = 12,
  parameter int BW  = 16,
  localparam int CW = $clog2(NCH),
  localparam int AW = CW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [BW-1:0] reg_wdata,
  output logic [BW-1:0] reg_rdata,
  input  logic          res_valid,
  input  logic [DW-1:0] res_data,
  input  logic          res_last,
  output logic          hit,
  output logic [CW-1:0] hit_chan,
  output logic          irq,
  output logic          lowpwr_req
);
  ctrl_t         ctrl;
  logic          ctrl_wr;
  logic [DW-1:0] thr [NCH];
  logic [BW-1:0] rd_q;
  logic          rd_res_q;
  logic [DW-1:0] store_rd;
  logic          mem_we;
  logic [CW-1:0] chan;
  logic          hit_raw;
  logic          acc;
  logic          scan_en, lp_en;
  logic [1:0]    irq_md, wr_md;

  assign scan_en = ctrl.scan_en;
  assign lp_en   = ctrl.lp_en;
  assign irq_md  = ctrl.irq;
  assign wr_md   = ctrl.wr;
  assign acc     = res_valid && scan_en;

  adc_scan_regs #(.NCH(NCH), .DW(DW), .BW(BW)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .ctrl(ctrl), .ctrl_wr(ctrl_wr), .thr(thr), .rd_q(rd_q), .rd_res_q(rd_res_q)
  );

  adc_scan_cmp #(.NCH(NCH), .DW(DW)) u_cmp (
    .mode(ctrl.cmp), .res(res_data), .chan(chan), .thr(thr), .hit_raw(hit_raw)
  );

  adc_scan_store #(.NCH(NCH), .DW(DW)) u_store (
    .clk(clk), .rst(rst), .acc(acc), .mode(ctrl.wr), .res(res_data), .chan(chan),
    .ptr_clr(ctrl_wr), .rd_addr(reg_addr[CW-1:0]), .rd_data(store_rd), .mem_we(mem_we)
  );

  adc_scan_seq #(.NCH(NCH)) u_seq (
    .clk(clk), .rst(rst), .acc(acc), .last(res_last), .hit_raw(hit_raw),
    .wmode(ctrl.wr), .imode(ctrl.irq), .lp_en(ctrl.lp_en), .chan(chan),
    .hit(hit), .hit_chan(hit_chan), .irq(irq), .lowpwr_req(lowpwr_req)
  );

  assign reg_rdata = rd_res_q ? {{(BW-DW){1'b0}}, store_rd} : rd_q;
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk (
  input logic       clk,
  input logic       rst,
  input logic       res_valid,
  input logic       res_last,
  input logic       scan_en,
  input logic       lp_en,
  input logic [1:0] irq_md,
  input logic [1:0] wr_md,
  input logic       mem_we,
  input logic       hit,
  input logic       irq,
  input logic       lowpwr_req
);
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !(res_valid && scan_en) |=> !hit && !irq && !lowpwr_req);

  p_irq_off_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_md == 2'b00) |=> !irq);

  p_store_mode_r7: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (wr_md == 2'b00 || wr_md == 2'b01) && res_valid && scan_en);

  p_rsvd_nohit_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_md == 2'b11) |=> !hit);

  p_lp_cause_r10: assert property (@(posedge clk) disable iff (rst)
    lowpwr_req |-> $past(res_valid && res_last && scan_en && lp_en));

  p_seq_irq_r9: assert property (@(posedge clk) disable iff (rst)
    (irq_md == 2'b01 || irq_md == 2'b11) && !res_last |=> !irq);
endmodule

bind adc_thresh_scan adc_scan_chk u_chk (
  .clk(clk), .rst(rst), .res_valid(res_valid), .res_last(res_last),
  .scan_en(scan_en), .lp_en(lp_en), .irq_md(irq_md), .wr_md(wr_md),
  .mem_we(mem_we), .hit(hit), .irq(irq), .lowpwr_req(lowpwr_req)
);

// File: tb/tb_adc_thresh_scan.sv
`timescale 1ns/1ps
module tb_adc_thresh_scan;
  localparam int NCH = 16;
  localparam int DW  = 12;
  localparam int BW  = 16;
  localparam int CW  = 4;
  localparam int AW  = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [BW-1:0] reg_wdata = '0;
  logic [BW-1:0] reg_rdata;
  logic          res_valid = 1'b0;
  logic [DW-1:0] res_data = '0;
  logic          res_last = 1'b0;
  logic          hit;
  logic [CW-1:0] hit_chan;
  logic          irq;
  logic          lowpwr_req;

  int errs = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  adc_thresh_scan #(.NCH(NCH), .DW(DW), .BW(BW)) dut (.*);

  // reference state
  logic [7:0]    m_ctrl = '0;
  int            m_thr [NCH];
  int            m_mem [NCH];
  int            m_ptr = 0;
  int            m_ch = 0;
  bit            m_sticky = 0;

  typedef struct packed {
    logic       acc;
    logic       irq;
    logic       hit;
    logic       lp;
    logic [3:0] ch;
  } exp_t;
  exp_t  q_exp [$];
  string q_tag [$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit m_cmp(input int r, input int ch);
    int lo, hi;
    lo = m_thr[ch & ~1];
    hi = m_thr[ch | 1];
    case (m_ctrl[7:6])
      2'd0: return r < m_thr[ch];
      2'd1: return r > m_thr[ch];
      2'd2: return (r >= lo) && (r <= hi);
      default: return (r < lo) || (r > hi);
    endcase
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    res_valid = 0;
    reg_we = 1; reg_addr = AW'(a); reg_wdata = BW'(d);
    @(posedge clk);
    #1 reg_we = 0;
    if (a == 0) begin m_ctrl = d[7:0]; m_ptr = 0; end
    else if (a >= NCH && a < 2*NCH) m_thr[a-NCH] = d & 12'hFFF;
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    @(negedge clk);
    res_valid = 0;
    reg_addr = AW'(a);
    @(negedge clk);
    chk(int'(reg_rdata) == exp, tag, int'(reg_rdata), exp);
  endtask

  task automatic send(input int r, input bit last, input string tag);
    exp_t e;
    bit h, seen;
    @(negedge clk);
    res_valid = 1; res_data = DW'(r); res_last = last;
    @(posedge clk);
    #1;
    e = '0;
    if (m_ctrl[0]) begin
      h    = m_cmp(r, m_ch) && m_ctrl[5:4] != 2'd3;
      seen = m_sticky || h;
      e.acc = 1; e.hit = h; e.ch = 4'(m_ch);
      case (m_ctrl[3:2])
        2'd0: e.irq = 0;
        2'd1: e.irq = last;
        2'd2: e.irq = h;
        default: e.irq = last && seen;
      endcase
      e.lp = last && m_ctrl[1];
      if (m_ctrl[5:4] == 2'd0) begin m_mem[m_ptr] = r; m_ptr = (m_ptr + 1) % NCH; end
      else if (m_ctrl[5:4] == 2'd1) m_mem[m_ch] = r;
      m_ch = last ? 0 : (m_ch + 1) % NCH;
      m_sticky = last ? 0 : seen;
    end
    q_exp.push_back(e);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    res_valid = 0; res_last = 0;
    @(negedge clk);
    chk(!hit && !irq && !lowpwr_req, tag, {hit, irq, lowpwr_req}, 0);
  endtask

  // monitor: one item per accepted edge, sampled on the following falling edge
  always @(negedge clk) begin
    if (q_exp.size() > 0) begin
      exp_t e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      chk(hit == e.hit, {t, " hit"}, hit, e.hit);
      chk(irq == e.irq, {t, " irq"}, irq, e.irq);
      chk(lowpwr_req == e.lp, {t, " lowpwr"}, lowpwr_req, e.lp);
      if (e.acc) chk(hit_chan == e.ch, {t, " chan"}, hit_chan, e.ch);
    end
  end

  initial begin
    #1000000;
    errs++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin m_thr[i] = 0; m_mem[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst = 0;

    // R1 reset state
    @(negedge clk);
    chk(!hit && !irq && !lowpwr_req, "R1 outputs after reset", {hit, irq, lowpwr_req}, 0);
    rd(0, 0, "R1 ctrl reset");
    rd(NCH + 5, 0, "R1 threshold reset");
    wr(0, 16'hFFFF);
    rd(0, 16'h00FF, "R1 upper bits read zero");
    wr(0, 0);

    // R2 thresholds
    wr(NCH + 0, 100); wr(NCH + 1, 200); wr(NCH + 2, 1000); wr(NCH + 3, 3000);
    wr(NCH + 4, 500); wr(NCH + 5, 600);
    wr(NCH + 2, 16'hF3E8);
    rd(NCH + 2, 1000, "R2 threshold readback");

    // R4 less-than, store by channel, irq on hit
    wr(0, 8'h19);
    send(50, 0, "R4 lt"); send(250, 0, "R4 lt"); send(999, 0, "R4 lt"); send(3000, 1, "R4 lt equal");
    idle("R12 pulses end");
    rd(2*NCH + 0, 50, "R6 chan slot0");
    rd(2*NCH + 3, 3000, "R6 chan slot3");

    // R4 greater-than
    wr(0, 8'h59);
    send(101, 0, "R4 gt"); send(200, 0, "R4 gt equal"); send(500, 0, "R4 gt"); send(3001, 1, "R4 gt");
    idle("R12 gt idle");

    // R5 inside window
    wr(0, 8'h99);
    send(100, 0, "R5 in lo edge"); send(200, 0, "R5 in hi edge"); send(999, 0, "R5 in below");
    send(3001, 0, "R5 in above"); send(550, 1, "R5 in pair2");
    idle("R5 idle");

    // R5 outside window
    wr(0, 8'hD9);
    send(99, 0, "R5 out below"); send(100, 0, "R5 out lo edge"); send(3000, 0, "R5 out hi edge");
    send(3001, 1, "R5 out above");
    idle("R5 out idle");

    // R3 wrap of the tag over a long pass
    wr(0, 8'h19);
    for (int i = 0; i < 18; i++) send(4000, 0, "R3 wrap");
    send(4000, 1, "R3 wrap end");
    send(50, 1, "R3 restart at 0");
    idle("R3 idle");

    // R8 + R10 end-of-pass interrupt, low-power request
    wr(0, 8'h17);
    send(50, 0, "R8 seq mode"); send(50, 0, "R8 seq mode"); send(50, 1, "R10 seq end");
    idle("R10 idle");
    wr(0, 8'h15);
    send(50, 1, "R10 lp disabled");
    // R8 mode 0
    wr(0, 8'h11);
    send(50, 0, "R8 off"); send(50, 1, "R8 off end");

    // R9 interrupt after pass with hit
    wr(0, 8'h1D);
    send(50, 0, "R9 hit"); send(500, 0, "R9"); send(2000, 1, "R9 end with hit");
    send(500, 0, "R9 clean"); send(500, 0, "R9 clean"); send(2000, 1, "R9 end no hit");
    idle("R9 idle");

    // R6 pointer store, cleared by control write, not by end marker
    wr(0, 8'h01);
    send(11, 0, "R6 ptr"); send(12, 0, "R6 ptr"); send(13, 1, "R6 ptr");
    send(21, 0, "R6 ptr"); send(22, 0, "R6 ptr"); send(23, 1, "R6 ptr");
    idle("R6 idle");
    for (int i = 0; i < 6; i++) rd(2*NCH + i, m_mem[i], "R6 pointer slot");

    // R7 compare-only and reserved
    wr(0, 8'h29);
    send(7, 1, "R7 compare only");
    rd(2*NCH, 11, "R7 no store mode2");
    wr(0, 8'h39);
    send(7, 1, "R7 reserved");
    rd(2*NCH, 11, "R7 no store mode3");

    // R11 disabled scan ignored
    wr(0, 8'h19);
    send(50, 0, "R11 before");
    wr(0, 8'h18);
    send(5, 0, "R11 ignored"); send(6, 1, "R11 ignored");
    idle("R11 no output");
    rd(2*NCH + 1, m_mem[1], "R11 no store");
    wr(0, 8'h19);
    send(150, 1, "R11 tag kept at 1");
    idle("R11 end");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule